// File: doc/BRIEF.md
# Root Port Interrupt Aggregator

This block gathers the interrupt sources of one PCI Express root port and presents them to the host as a single level-sensitive line. Inbound message-signalled interrupt writes arrive as a strobe with a 64-bit address split into two words and a 32-bit data word. A write that hits the programmed vector address sets the status bit whose index equals the data value. Four legacy INTx assertion strobes set their own status bits.

Message interrupts are tracked at two levels. A 32-entry vector status word records which vectors fired. A single summary flag in the shared status register records that at least one vector was pending. The summary flag is sticky, so the host clears it with its own write once it has serviced the vector word. A simple 32-bit register port gives the host access to the mask, the status words and the target address. The output interrupt is a registered OR of every unmasked source.

Top module: `irqagg_top`

## Requirements
- R1: A message write with upper address word zero, lower address word equal to the target register (offset 0x430) and data N below 32 sets bit N of the vector status word (offset 0x42C), visible on the clock edge that samples the write.
- R2: A message write whose upper address word is nonzero, or whose lower word differs from the target register, changes no status bit.
- R3: A message write whose data is 32 or more changes no status bit.
- R4: A strobe on intx_assert[i] sets bit 16+i of the shared status register (offset 0x424).
- R5: Writing a word to 0x42C or 0x424 clears exactly the status bits written as 1; bits written as 0 keep their value.
- R6: Bit 23 of 0x424 (summary) is set on every cycle after the vector status word is nonzero, and stays set until the host writes 1 to bit 23, even once every vector bit has been cleared.
- R7: The mask register (offset 0x420) holds INTx masks in bits 19:16 and the summary mask in bit 23, resets to all of these set (0x008F0000), a 0 enables the source, and all other bits read 0.
- R8: irq_o is asserted one cycle after any unmasked INTx bit or an unmasked summary bit is set, and is low one cycle after none is.
- R9: When a set event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The target address register at 0x430 is readable and writable in all 32 bits and resets to 0.
- R11: After reset all status bits are 0 and irq_o is low.
- R12: A read returns data on reg_rdata one cycle after reg_rd_en; any offset other than 0x420, 0x424, 0x42C, 0x430 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_wr_valid | input | 1 | Inbound message write strobe |
| msi_wr_addr_hi | input | 32 | Upper word of the message address |
| msi_wr_addr_lo | input | 32 | Lower word of the message address |
| msi_wr_data | input | 32 | Message data (vector number) |
| intx_assert | input | 4 | Legacy INTx A..D assertion strobes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The checker watches, on every cycle, that accepted message writes land in the right vector bit, that no vector bit appears without an accepted write, that INTx strobes always land, that the summary flag follows and holds, that a one written to the vector word clears those bits, and that irq_o is both caused by and raised for unmasked pending sources. The bench scenarios show what properties cannot pin down alone: the exact read values and reset mask, the mixed clear patterns, the same-cycle set-versus-clear race as seen by software, the unmodelled offsets reading zero and the summary persisting after the vector word is empty.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int REG_AW = 12;
   localparam logic [REG_AW-1:0] OFS_MASK  = 12'h420;
   localparam logic [REG_AW-1:0] OFS_STAT  = 12'h424;
   localparam logic [REG_AW-1:0] OFS_MSTAT = 12'h42C;
   localparam logic [REG_AW-1:0] OFS_MADDR = 12'h430;
   localparam int INTX_LSB = 16;
   localparam int SUM_BIT  = 23;
endpackage

// File: rtl/irqagg_msi_vec.sv
module irqagg_msi_vec
   import irqagg_pkg::*;
#(
   parameter int NUM_MSI = 32,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_valid,
   input  logic [DATA_W-1:0]  hit_addr_hi,
   input  logic [DATA_W-1:0]  hit_addr_lo,
   input  logic [DATA_W-1:0]  hit_data,
   input  logic [DATA_W-1:0]  target_addr,
   input  logic               clr_en,
   input  logic [NUM_MSI-1:0] clr_bits,
   output logic               accept_o,
   output logic [NUM_MSI-1:0] stat_q
);
   localparam logic [DATA_W-1:0] VEC_LIMIT = DATA_W'(NUM_MSI);

   logic               addr_ok;
   logic               data_ok;
   logic [NUM_MSI-1:0] set_vec;
   logic [NUM_MSI-1:0] clr_vec;

   always_comb begin
      addr_ok  = (hit_addr_hi == '0) && (hit_addr_lo == target_addr);
      data_ok  = (hit_data < VEC_LIMIT);
      accept_o = hit_valid && addr_ok && data_ok;
      clr_vec  = clr_en ? clr_bits : '0;
   end

   for (genvar i = 0; i < NUM_MSI; i++) begin : g_vec
      always_comb set_vec[i] = accept_o && (hit_data == DATA_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          stat_q[i] <= 1'b0;
         else if (set_vec[i]) stat_q[i] <= 1'b1;
         else if (clr_vec[i]) stat_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqagg_intx.sv
module irqagg_intx #(
   parameter int NUM_INTX = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_INTX-1:0] set_in,
   input  logic                clr_en,
   input  logic [NUM_INTX-1:0] clr_bits,
   output logic [NUM_INTX-1:0] stat_q
);
   for (genvar i = 0; i < NUM_INTX; i++) begin : g_line
      logic clr_here;
      always_comb clr_here = clr_en && clr_bits[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         stat_q[i] <= 1'b0;
         else if (set_in[i]) stat_q[i] <= 1'b1;
         else if (clr_here)  stat_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
   import irqagg_pkg::*;
#(
   parameter int NUM_INTX = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   stat_word,
   input  logic [DATA_W-1:0]   mstat_word,
   output logic [NUM_INTX-1:0] mask_intx_q,
   output logic                mask_msi_q,
   output logic [DATA_W-1:0]   target_q,
   output logic                stat_wr_o,
   output logic                mstat_wr_o,
   output logic [DATA_W-1:0]   rdata
);
   logic              hit_mask;
   logic              hit_stat;
   logic              hit_mstat;
   logic              hit_maddr;
   logic [DATA_W-1:0] mask_word;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      hit_mask   = (addr == ADDR_W'(OFS_MASK));
      hit_stat   = (addr == ADDR_W'(OFS_STAT));
      hit_mstat  = (addr == ADDR_W'(OFS_MSTAT));
      hit_maddr  = (addr == ADDR_W'(OFS_MADDR));
      stat_wr_o  = wr_en && hit_stat;
      mstat_wr_o = wr_en && hit_mstat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_intx_q <= '1;
         mask_msi_q  <= 1'b1;
         target_q    <= '0;
      end else if (wr_en) begin
         if (hit_mask) begin
            mask_intx_q <= wdata[INTX_LSB +: NUM_INTX];
            mask_msi_q  <= wdata[SUM_BIT];
         end
         if (hit_maddr) target_q <= wdata;
      end
   end

   always_comb begin
      mask_word                       = '0;
      mask_word[INTX_LSB +: NUM_INTX] = mask_intx_q;
      mask_word[SUM_BIT]              = mask_msi_q;
      unique case (1'b1)
         hit_mask:  rd_mux = mask_word;
         hit_stat:  rd_mux = stat_word;
         hit_mstat: rd_mux = mstat_word;
         hit_maddr: rd_mux = target_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_MSI  = 32,
   parameter int NUM_INTX = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msi_wr_valid,
   input  logic [DATA_W-1:0]   msi_wr_addr_hi,
   input  logic [DATA_W-1:0]   msi_wr_addr_lo,
   input  logic [DATA_W-1:0]   msi_wr_data,
   input  logic [NUM_INTX-1:0] intx_assert,
   input  logic                reg_wr_en,
   input  logic                reg_rd_en,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq_o
);
   if (NUM_MSI < 2 || NUM_MSI > DATA_W) begin : g_bad_msi
      $error("NUM_MSI must lie in 2..DATA_W");
   end
   if (INTX_LSB + NUM_INTX > SUM_BIT) begin : g_bad_intx
      $error("INTx field overlaps the summary bit");
   end
   if (ADDR_W < REG_AW) begin : g_bad_aw
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [NUM_MSI-1:0]  msi_stat_q;
   logic [NUM_INTX-1:0] intx_q;
   logic [NUM_INTX-1:0] mask_intx_q;
   logic                mask_msi_q;
   logic [DATA_W-1:0]   target_q;
   logic                stat_wr;
   logic                mstat_wr;
   logic                msi_accept;
   logic                sum_q;
   logic                sum_clr;
   logic                irq_next;
   logic [DATA_W-1:0]   stat_word;
   logic [DATA_W-1:0]   mstat_word;

   irqagg_msi_vec #(.NUM_MSI(NUM_MSI), .DATA_W(DATA_W)) u_msi (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_valid   (msi_wr_valid),
      .hit_addr_hi (msi_wr_addr_hi),
      .hit_addr_lo (msi_wr_addr_lo),
      .hit_data    (msi_wr_data),
      .target_addr (target_q),
      .clr_en      (mstat_wr),
      .clr_bits    (reg_wdata[NUM_MSI-1:0]),
      .accept_o    (msi_accept),
      .stat_q      (msi_stat_q)
   );

   irqagg_intx #(.NUM_INTX(NUM_INTX)) u_intx (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_in   (intx_assert),
      .clr_en   (stat_wr),
      .clr_bits (reg_wdata[INTX_LSB +: NUM_INTX]),
      .stat_q   (intx_q)
   );

   always_comb begin
      stat_word                       = '0;
      stat_word[INTX_LSB +: NUM_INTX] = intx_q;
      stat_word[SUM_BIT]              = sum_q;
      mstat_word                      = DATA_W'(msi_stat_q);
      sum_clr  = stat_wr && reg_wdata[SUM_BIT];
      irq_next = (|(intx_q & ~mask_intx_q)) | (sum_q & ~mask_msi_q);
   end

   irqagg_regs #(.NUM_INTX(NUM_INTX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .rd_en       (reg_rd_en),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .stat_word   (stat_word),
      .mstat_word  (mstat_word),
      .mask_intx_q (mask_intx_q),
      .mask_msi_q  (mask_msi_q),
      .target_q    (target_q),
      .stat_wr_o   (stat_wr),
      .mstat_wr_o  (mstat_wr),
      .rdata       (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= 1'b0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= irq_next;
         if (msi_accept || (|msi_stat_q)) sum_q <= 1'b1;
         else if (sum_clr)                sum_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int NUM_MSI  = 32,
   parameter int NUM_INTX = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msi_wr_valid,
   input logic [DATA_W-1:0]   msi_wr_addr_hi,
   input logic [DATA_W-1:0]   msi_wr_addr_lo,
   input logic [DATA_W-1:0]   msi_wr_data,
   input logic [NUM_INTX-1:0] intx_assert,
   input logic                reg_wr_en,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic                irq_o,
   input logic [NUM_MSI-1:0]  msi_stat_q,
   input logic [NUM_INTX-1:0] intx_q,
   input logic                sum_q,
   input logic [NUM_INTX-1:0] mask_intx_q,
   input logic                mask_msi_q,
   input logic [DATA_W-1:0]   target_q
);
   localparam int IDX_W = $clog2(NUM_MSI);

   logic good_msi;
   logic pending;
   logic sum_wr1;
   logic mstat_wr;
   always_comb begin
      good_msi = msi_wr_valid && (msi_wr_addr_hi == '0) &&
                 (msi_wr_addr_lo == target_q) && (msi_wr_data < DATA_W'(NUM_MSI));
      pending  = (|(intx_q & ~mask_intx_q)) || (sum_q && !mask_msi_q);
      sum_wr1  = reg_wr_en && (reg_addr == ADDR_W'(OFS_STAT)) && reg_wdata[SUM_BIT];
      mstat_wr = reg_wr_en && (reg_addr == ADDR_W'(OFS_MSTAT));
   end

   AST_MSI_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      good_msi |=> msi_stat_q[$past(msi_wr_data[IDX_W-1:0])]); // R1
   AST_NO_STRAY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      ((msi_stat_q & ~$past(msi_stat_q)) != '0) |-> $past(good_msi)); // R2
   AST_INTX_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|intx_assert) |=> ((intx_q & $past(intx_assert)) == $past(intx_assert))); // R4
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mstat_wr && !msi_wr_valid) |=> ((msi_stat_q & $past(reg_wdata[NUM_MSI-1:0])) == '0)); // R5
   AST_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|msi_stat_q) |=> sum_q); // R6
   AST_SUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q && !sum_wr1) |=> sum_q); // R6
   AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(pending)); // R8
   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> irq_o); // R8
endmodule

bind irqagg_top irqagg_chk #(
   .NUM_MSI(NUM_MSI), .NUM_INTX(NUM_INTX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .msi_wr_valid   (msi_wr_valid),
   .msi_wr_addr_hi (msi_wr_addr_hi),
   .msi_wr_addr_lo (msi_wr_addr_lo),
   .msi_wr_data    (msi_wr_data),
   .intx_assert    (intx_assert),
   .reg_wr_en      (reg_wr_en),
   .reg_addr       (reg_addr),
   .reg_wdata      (reg_wdata),
   .irq_o          (irq_o),
   .msi_stat_q     (msi_stat_q),
   .intx_q         (intx_q),
   .sum_q          (sum_q),
   .mask_intx_q    (mask_intx_q),
   .mask_msi_q     (mask_msi_q),
   .target_q       (target_q)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
   localparam int AW = 12;
   localparam logic [AW-1:0] A_MASK = 12'h420, A_STAT = 12'h424,
                             A_MST  = 12'h42C, A_TGT  = 12'h430;
   localparam logic [31:0] TGT = 32'h1000_00C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_wr_valid = 1'b0;
   logic [31:0] msi_wr_addr_hi = '0, msi_wr_addr_lo = '0, msi_wr_data = '0;
   logic [3:0]  intx_assert = '0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;
   logic        probe = 1'b0;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   irqagg_top u0 (
      .clk(clk), .rst_n(rst_n), .msi_wr_valid(msi_wr_valid),
      .msi_wr_addr_hi(msi_wr_addr_hi), .msi_wr_addr_lo(msi_wr_addr_lo),
      .msi_wr_data(msi_wr_data), .intx_assert(intx_assert),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

   // monitor: compares one expected item per strobed cycle
   initial begin
      forever begin
         @(posedge clk);
         if (reg_rd_en || probe) begin
            #1;
            if (sb.size() == 0) begin
               n_bad++;
               $display("FAIL scoreboard empty: actual %h expected none", reg_rdata);
            end else begin
               item_t it;
               logic [31:0] act;
               it  = sb.pop_front();
               act = it.is_irq ? {31'd0, irq_o} : reg_rdata;
               n_cmp++;
               if (act !== it.exp) begin
                  n_bad++;
                  $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
               end
            end
         end
      end
   end

   task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
      sb.push_back('{1'b0, e, tag});
      reg_addr = a; reg_rd_en = 1'b1;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic irq_chk(input logic e, input string tag);
      sb.push_back('{1'b1, {31'd0, e}, tag});
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic msi(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] d);
      msi_wr_addr_hi = hi; msi_wr_addr_lo = lo; msi_wr_data = d; msi_wr_valid = 1'b1;
      @(negedge clk);
      msi_wr_valid = 1'b0;
   endtask

   task automatic intx(input logic [3:0] m);
      intx_assert = m;
      @(negedge clk);
      intx_assert = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state, R7 reset mask
      rd_chk(A_STAT, 32'h0, "R11 status after reset");
      rd_chk(A_MST,  32'h0, "R11 vector word after reset");
      rd_chk(A_MASK, 32'h008F_0000, "R7 mask reset value");
      rd_chk(A_TGT,  32'h0, "R10 target reset value");
      irq_chk(1'b0, "R11 irq low after reset");
      // R10 target programming
      wr(A_TGT, TGT);
      rd_chk(A_TGT, TGT, "R10 target readback");
      // R1 accepted write
      msi(32'h0, TGT, 32'd5);
      rd_chk(A_MST, 32'h0000_0020, "R1 vector 5 set");
      rd_chk(A_STAT, 32'h0080_0000, "R6 summary set");
      irq_chk(1'b0, "R7 summary masked");
      // R2 address misses, R3 out-of-range data
      msi(32'h1, TGT, 32'd7);
      msi(32'h0, TGT + 32'd4, 32'd8);
      rd_chk(A_MST, 32'h0000_0020, "R2 address misses ignored");
      msi(32'h0, TGT, 32'd32);
      msi(32'h0, TGT, 32'd40);
      rd_chk(A_MST, 32'h0000_0020, "R3 data >= 32 ignored");
      msi(32'h0, TGT, 32'd31);
      rd_chk(A_MST, 32'h8000_0020, "R1 vector 31 set");
      // R8 unmask summary
      wr(A_MASK, 32'h000F_0000);
      irq_chk(1'b1, "R8 irq on unmasked summary");
      // R5 partial clear, R6 sticky summary
      wr(A_MST, 32'h0000_0020);
      rd_chk(A_MST, 32'h8000_0000, "R5 only written bit cleared");
      wr(A_MST, 32'h8000_0000);
      rd_chk(A_MST, 32'h0, "R5 vector word empty");
      rd_chk(A_STAT, 32'h0080_0000, "R6 summary held after vectors clear");
      irq_chk(1'b1, "R6 irq held by summary");
      wr(A_STAT, 32'h0080_0000);
      rd_chk(A_STAT, 32'h0, "R6 summary cleared by host");
      irq_chk(1'b0, "R8 irq drops");
      // R4 INTx
      intx(4'b0101);
      rd_chk(A_STAT, 32'h0005_0000, "R4 INTx A and C set");
      irq_chk(1'b0, "R7 INTx masked");
      wr(A_MASK, 32'h008B_0000);
      irq_chk(1'b1, "R8 irq on unmasked INTx C");
      wr(A_STAT, 32'h0001_0000);
      rd_chk(A_STAT, 32'h0004_0000, "R5 INTx A cleared alone");
      wr(A_STAT, 32'h0004_0000);
      rd_chk(A_STAT, 32'h0, "R5 INTx C cleared");
      irq_chk(1'b0, "R8 irq low with nothing pending");
      // R9 set beats clear
      msi_wr_addr_hi = '0; msi_wr_addr_lo = TGT; msi_wr_data = 32'd3; msi_wr_valid = 1'b1;
      reg_addr = A_MST; reg_wdata = 32'h8; reg_wr_en = 1'b1;
      @(negedge clk);
      msi_wr_valid = 1'b0; reg_wr_en = 1'b0;
      rd_chk(A_MST, 32'h0000_0008, "R9 vector set wins");
      intx_assert = 4'b0010;
      reg_addr = A_STAT; reg_wdata = 32'h0002_0000; reg_wr_en = 1'b1;
      @(negedge clk);
      intx_assert = '0; reg_wr_en = 1'b0;
      rd_chk(A_STAT, 32'h0082_0000, "R9 INTx set wins");
      // R12 unmodelled offsets, R7 unused mask bits
      wr(12'h0C0, 32'hFFFF_FFFF);
      rd_chk(12'h0C0, 32'h0, "R12 vector offset reads zero");
      rd_chk(12'h100, 32'h0, "R12 unknown offset reads zero");
      wr(A_MASK, 32'hFFFF_FFFF);
      rd_chk(A_MASK, 32'h008F_0000, "R7 unused mask bits read zero");
      repeat (2) @(negedge clk);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard left %0d items: actual %0d expected 0", sb.size(), sb.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule